// File: doc/BRIEF.md
# Recursive Temporal Smoothing and Derivative Filter

This block applies a second-order causal IIR filter along the time axis of a video stream. Spatially smoothed pixels arrive one per handshake in raster order, each with its location in the frame. For every pixel the block returns a temporally smoothed value and an estimate of its temporal derivative. The filter is recursive, so only three words of history per pixel location are needed, not a window of past frames.

The per-pixel history lives in an external memory that the block reaches through a read port and a write port. The read for a pixel is issued in the same cycle the pixel is accepted, and its data is expected one cycle later. The updated history is written back when the pixel's results are registered. Writes come out in the order the pixels were accepted, so neighbouring pixels in the stream never race on the same word. The coefficients are signed fixed-point parameters derived from the filter time constant. The defaults correspond to a time constant of two frames.

Top module: `temporal_iir_filter`

## Requirements
- R1: After reset `out_valid`, `st_wr_en` and `st_rd_en` are low and `in_ready` is high.
- R2: `st_rd_en` is high exactly in cycles where `in_valid` and `in_ready` are both high, and `st_rd_addr` then equals `in_addr`. The read data is taken one cycle later.
- R3: Each accepted pixel produces exactly one write, to its own address, in acceptance order, in the cycle its results are loaded into the output register. `st_wr_data` packs the new state as bits [3D-1:2D] = y, [2D-1:D] = new w, [D-1:0] = previous w, where D = DATA_W.
- R4: Pixels accepted before the second frame-start after reset are computed with all history words taken as zero, whatever the memory returns.
- R5: The intermediate value is w = I − rz(c2r·w1) − rz(cr2·w2). I is the zero-extended pixel, w1 and w2 are the two stored intermediates, and every result wraps to DATA_W bits.
- R6: The second-order term is R = rz(cq2·w) + rz(c2q2·w1) + rz(cq2·w2), and the filter output is y = R − rz(cr·y1).
- R7: The smoothed output is `out_smooth` = rz(cq·y) + rz(cq·y1).
- R8: The derivative output is `out_deriv` = rz(cinvtau·(R − smooth)), where the difference is formed with one extra bit.
- R9: rz(p) is the coefficient product divided by 2^FRAC_W and rounded toward zero, so negative products round up, not down.
- R10: While `out_valid` is high and `out_ready` is low, both outputs hold their values, `in_ready` is low and no pixel is accepted.
- R11: Without backpressure, results for a pixel accepted at clock edge k are visible after edge k+1, and results appear in acceptance order.
- R12: Frame-start asserted on an accepted pixel ends the zero-history period only the second time it is seen after reset. That pixel already uses the stored history, and later frame-starts have no effect on the arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can accept a pixel |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_addr | input | ADDR_W | Pixel location, used as history address |
| in_pix | input | PIX_W | Spatially smoothed pixel, unsigned |
| st_rd_en | output | 1 | History read request |
| st_rd_addr | output | ADDR_W | History read address |
| st_rd_data | input | 3*DATA_W | History read data, one cycle after the request |
| st_wr_en | output | 1 | History write strobe |
| st_wr_addr | output | ADDR_W | History write address |
| st_wr_data | output | 3*DATA_W | Updated history word |
| out_valid | output | 1 | Results present |
| out_ready | input | 1 | Downstream takes results |
| out_smooth | output | DATA_W | Temporally smoothed pixel, signed |
| out_deriv | output | DATA_W | Temporal derivative, signed |

## Verification
The bench fills the history memory with a nonzero pattern before the first frame. A design that did not force zero history on the first frame would show large offsets in every first-frame output. A design that cleared the first-frame flag on the first frame-start, or never cleared it, would mismatch on the second frame. A falling step in brightness drives the derivative negative, which exposes rounding toward minus infinity by one LSB. Backpressure comes both as random and as regular long stalls. The stalls catch read data that is lost while the pipeline waits, which would corrupt both the writeback word and the outputs, as well as outputs that change while held.

// File: rtl/tiir_pkg.sv
package tiir_pkg;
    // Fixed-point coefficients for time constant 2, 12 fractional bits
    localparam int DEF_FRAC   = 12;
    localparam int DEF_CQ     = 819;    // q      =  0.2
    localparam int DEF_CR     = -2458;  // r      = -0.6
    localparam int DEF_CQ2    = 164;    // q^2    =  0.04
    localparam int DEF_C2Q2   = 328;    // 2q^2   =  0.08
    localparam int DEF_C2R    = -4915;  // 2r     = -1.2
    localparam int DEF_CR2    = 1475;   // r^2    =  0.36
    localparam int DEF_CINVT  = 2048;   // 1/tau  =  0.5
endpackage

// File: rtl/tiir_mulrz.sv
module tiir_mulrz #(
    parameter int A_W = 16,
    parameter int C_W = 16,
    parameter int F_W = 12,
    parameter int O_W = 16
) (
    input  logic signed [A_W-1:0] a,
    input  logic signed [C_W-1:0] c,
    output logic signed [O_W-1:0] p
);
    localparam int P_W = A_W + C_W;

    logic signed [P_W-1:0] full;
    logic signed [P_W-1:0] bias;
    logic signed [P_W-1:0] sum;

    always_comb begin
        full = P_W'(a) * P_W'(c);
        bias = '0;
        // negative products get a bias so the shift rounds toward zero
        if (full[P_W-1]) bias[F_W-1:0] = '1;
        sum = full + bias;
        p   = O_W'(sum >>> F_W);
    end
endmodule

// File: rtl/tiir_arith.sv
module tiir_arith #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 12,
    parameter int CQ     = 819,
    parameter int CR     = -2458,
    parameter int CQ2    = 164,
    parameter int C2Q2   = 328,
    parameter int C2R    = -4915,
    parameter int CR2    = 1475,
    parameter int CINVT  = 2048
) (
    input  logic signed [DATA_W-1:0] pix,
    input  logic signed [DATA_W-1:0] w1,
    input  logic signed [DATA_W-1:0] w2,
    input  logic signed [DATA_W-1:0] y1,
    output logic signed [DATA_W-1:0] w,
    output logic signed [DATA_W-1:0] rr,
    output logic signed [DATA_W-1:0] y,
    output logic signed [DATA_W-1:0] sm,
    output logic signed [DATA_W-1:0] de
);
    localparam int NPROD = 8;
    localparam logic signed [COEF_W-1:0] K_C2R   = COEF_W'(C2R);
    localparam logic signed [COEF_W-1:0] K_CR2   = COEF_W'(CR2);
    localparam logic signed [COEF_W-1:0] K_CQ2   = COEF_W'(CQ2);
    localparam logic signed [COEF_W-1:0] K_C2Q2  = COEF_W'(C2Q2);
    localparam logic signed [COEF_W-1:0] K_CR    = COEF_W'(CR);
    localparam logic signed [COEF_W-1:0] K_CQ    = COEF_W'(CQ);
    localparam logic signed [COEF_W-1:0] K_CINVT = COEF_W'(CINVT);

    logic signed [DATA_W-1:0] op_a [NPROD];
    logic signed [COEF_W-1:0] op_c [NPROD];
    logic signed [DATA_W-1:0] prod [NPROD];
    logic signed [DATA_W:0]   diff;
    logic signed [DATA_W-1:0] dprod;

    always_comb begin
        op_a[0] = w1;  op_c[0] = K_C2R;
        op_a[1] = w2;  op_c[1] = K_CR2;
        op_a[2] = w;   op_c[2] = K_CQ2;
        op_a[3] = w1;  op_c[3] = K_C2Q2;
        op_a[4] = w2;  op_c[4] = K_CQ2;
        op_a[5] = y1;  op_c[5] = K_CR;
        op_a[6] = y;   op_c[6] = K_CQ;
        op_a[7] = y1;  op_c[7] = K_CQ;
    end

    for (genvar i = 0; i < NPROD; i++) begin : g_prod
        tiir_mulrz #(.A_W(DATA_W), .C_W(COEF_W), .F_W(FRAC_W), .O_W(DATA_W)) u_mul (
            .a(op_a[i]), .c(op_c[i]), .p(prod[i])
        );
    end

    tiir_mulrz #(.A_W(DATA_W+1), .C_W(COEF_W), .F_W(FRAC_W), .O_W(DATA_W)) u_mul_der (
        .a(diff), .c(K_CINVT), .p(dprod)
    );

    always_comb begin
        w    = pix - prod[0] - prod[1];
        rr   = prod[2] + prod[3] + prod[4];
        y    = rr - prod[5];
        sm   = prod[6] + prod[7];
        diff = {rr[DATA_W-1], rr} - {sm[DATA_W-1], sm};
        de   = dprod;
    end
endmodule

// File: rtl/temporal_iir_filter.sv
module temporal_iir_filter
    import tiir_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PIX_W  = 12,
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int FRAC_W = DEF_FRAC,
    parameter int CQ     = DEF_CQ,
    parameter int CR     = DEF_CR,
    parameter int CQ2    = DEF_CQ2,
    parameter int C2Q2   = DEF_C2Q2,
    parameter int C2R    = DEF_C2R,
    parameter int CR2    = DEF_CR2,
    parameter int CINVT  = DEF_CINVT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_sof,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [PIX_W-1:0]      in_pix,
    output logic                  st_rd_en,
    output logic [ADDR_W-1:0]     st_rd_addr,
    input  logic [3*DATA_W-1:0]   st_rd_data,
    output logic                  st_wr_en,
    output logic [ADDR_W-1:0]     st_wr_addr,
    output logic [3*DATA_W-1:0]   st_wr_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [DATA_W-1:0]     out_smooth,
    output logic [DATA_W-1:0]     out_deriv
);
    localparam int ST_W = 3 * DATA_W;

    typedef struct packed {
        logic                     s1_valid;
        logic                     s1_have;
        logic                     s1_zero;
        logic [ADDR_W-1:0]        s1_addr;
        logic signed [DATA_W-1:0] s1_pix;
        logic [ST_W-1:0]          s1_state;
        logic                     o_valid;
        logic signed [DATA_W-1:0] o_smooth;
        logic signed [DATA_W-1:0] o_deriv;
        logic                     seen_sof;
        logic                     first;
    } regs_t;

    localparam regs_t RST_VAL = '{first: 1'b1, default: '0};

    regs_t r_d, r_q;

    logic                     adv, accept;
    logic [ST_W-1:0]          cur_state;
    logic signed [DATA_W-1:0] y1, w1, w2;
    logic signed [DATA_W-1:0] w_n, rr_n, y_n, sm_n, de_n;

    tiir_arith #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
        .CQ(CQ), .CR(CR), .CQ2(CQ2), .C2Q2(C2Q2), .C2R(C2R), .CR2(CR2), .CINVT(CINVT)
    ) u_arith (
        .pix(r_q.s1_pix), .w1(w1), .w2(w2), .y1(y1),
        .w(w_n), .rr(rr_n), .y(y_n), .sm(sm_n), .de(de_n)
    );

    always_comb begin
        r_d    = r_q;
        adv    = !r_q.o_valid || out_ready;
        accept = in_valid && adv;

        // history: held copy if the stage stalled, else fresh memory data
        cur_state = r_q.s1_have ? r_q.s1_state : st_rd_data;
        if (r_q.s1_zero) cur_state = '0;
        y1 = cur_state[3*DATA_W-1:2*DATA_W];
        w1 = cur_state[2*DATA_W-1:DATA_W];
        w2 = cur_state[DATA_W-1:0];

        if (r_q.o_valid && out_ready) r_d.o_valid = 1'b0;

        if (r_q.s1_valid) begin
            if (adv) begin
                r_d.o_valid  = 1'b1;
                r_d.o_smooth = sm_n;
                r_d.o_deriv  = de_n;
                r_d.s1_valid = 1'b0;
            end else if (!r_q.s1_have) begin
                r_d.s1_have  = 1'b1;
                r_d.s1_state = st_rd_data;
            end
        end

        if (accept) begin
            r_d.s1_valid = 1'b1;
            r_d.s1_have  = 1'b0;
            r_d.s1_zero  = r_q.first && !(in_sof && r_q.seen_sof);
            r_d.s1_addr  = in_addr;
            r_d.s1_pix   = DATA_W'(in_pix);
            if (in_sof) begin
                r_d.seen_sof = 1'b1;
                if (r_q.seen_sof) r_d.first = 1'b0;
            end
        end

        in_ready   = adv;
        st_rd_en   = accept;
        st_rd_addr = in_addr;
        st_wr_en   = r_q.s1_valid && adv;
        st_wr_addr = r_q.s1_addr;
        st_wr_data = {y_n, w_n, w1};
        out_valid  = r_q.o_valid;
        out_smooth = r_q.o_smooth;
        out_deriv  = r_q.o_deriv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/temporal_iir_filter_chk.sv
module temporal_iir_filter_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              st_rd_en,
    input logic [ADDR_W-1:0] st_rd_addr,
    input logic              st_wr_en,
    input logic [ADDR_W-1:0] st_wr_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_smooth,
    input logic [DATA_W-1:0] out_deriv
);
    logic [1:0]        pend_q;
    logic [ADDR_W-1:0] last_rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            last_rd_q <= '0;
        end else begin
            pend_q <= pend_q + {1'b0, st_rd_en} - {1'b0, st_wr_en};
            if (st_rd_en) last_rd_q <= st_rd_addr;
        end
    end

    AST_RD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd_en |-> in_valid);                                               // R2
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= 2'd1);                                                      // R3
    AST_WR_MATCHES_RD: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |-> (pend_q == 2'd1) && (st_wr_addr == last_rd_q));         // R3
    AST_WR_LOADS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |=> out_valid);                                              // R11
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_smooth) && $stable(out_deriv)); // R10
    AST_NO_TAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !st_rd_en && !st_wr_en);                // R10
endmodule

bind temporal_iir_filter temporal_iir_filter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/temporal_iir_filter_test.sv
module temporal_iir_filter_test;
    localparam int AW   = 6;
    localparam int PW   = 12;
    localparam int DW   = 16;
    localparam int NPIX = 16;
    localparam longint FR = 4096;
    localparam int CQ = 819, CR = -2458, CQ2 = 164, C2Q2 = 328, C2R = -4915, CR2 = 1475, CIT = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [PW-1:0] in_pix = '0;
    logic in_ready, st_rd_en, st_wr_en, out_valid;
    logic [AW-1:0] st_rd_addr, st_wr_addr;
    logic [3*DW-1:0] st_rd_data, st_wr_data;
    logic signed [DW-1:0] out_smooth, out_deriv;

    always #10 clk = ~clk;

    temporal_iir_filter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
        .in_addr(in_addr), .in_pix(in_pix), .st_rd_en(st_rd_en), .st_rd_addr(st_rd_addr),
        .st_rd_data(st_rd_data), .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr),
        .st_wr_data(st_wr_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_smooth(out_smooth), .out_deriv(out_deriv)
    );

    // history memory: one-cycle read latency, filled with a nonzero pattern
    logic [3*DW-1:0] mem [1<<AW];
    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = {3{16'h5A3C}} ^ 48'(i);
        st_rd_data = {3{16'h7777}};
    end
    always @(posedge clk) begin
        if (st_rd_en) st_rd_data <= mem[st_rd_addr];
        if (st_wr_en) mem[st_wr_addr] <= st_wr_data;
    end

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    // bench model state
    int mw1 [1<<AW], mw2 [1<<AW], my1 [1<<AW];
    bit bfirst = 1, bseen = 0, cur_fast = 0;
    int q_sm[$], q_de[$], q_cyc[$];
    bit q_fast[$];
    string q_tag[$];
    int qw_addr[$];
    logic [3*DW-1:0] qw_data[$];
    bit pend = 0;
    int pend_pix, pend_addr;
    bit pend_sof;
    bit prev_hold = 0;
    logic signed [DW-1:0] prev_sm, prev_de;

    function automatic int wrp(input longint x);
        logic signed [DW-1:0] t;
        t = x[DW-1:0];
        return int'(t);
    endfunction

    function automatic longint mulz(input longint a, input longint c);
        return (a * c) / FR;   // integer division truncates toward zero (R9)
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_accept(input int pix, input int a, input bit sof);
        int w1, w2, y1, w, r2, y, sm, de;
        bit zero, r12;
        string tag;
        zero = bfirst && !(sof && bseen);
        r12  = sof && bseen && bfirst;
        if (sof) begin
            if (bseen) bfirst = 0;
            bseen = 1;
        end
        w1 = zero ? 0 : mw1[a];
        w2 = zero ? 0 : mw2[a];
        y1 = zero ? 0 : my1[a];
        w  = wrp(pix - mulz(C2R, w1) - mulz(CR2, w2));
        r2 = wrp(mulz(CQ2, w) + mulz(C2Q2, w1) + mulz(CQ2, w2));
        y  = wrp(r2 - mulz(CR, y1));
        sm = wrp(mulz(CQ, y) + mulz(CQ, y1));
        de = wrp(mulz(CIT, longint'(r2) - sm));
        mw2[a] = w1; mw1[a] = w; my1[a] = y;
        tag = "R7";
        if (zero) tag = {tag, " R4"};
        if (r12)  tag = {tag, " R12"};
        q_sm.push_back(sm); q_de.push_back(de); q_tag.push_back(tag);
        q_cyc.push_back(cyc); q_fast.push_back(cur_fast);
        qw_addr.push_back(a);
        qw_data.push_back({DW'(y), DW'(w), DW'(w1)});
    endtask

    task automatic observe();
        bit acc;
        acc = in_valid && in_ready;
        check(st_rd_en === acc, "R2 read strobe", st_rd_en, acc);
        if (acc) check(st_rd_addr == in_addr, "R2 read address", st_rd_addr, in_addr);
        if (out_valid && !out_ready) check(!in_ready, "R10 ready low while held", in_ready, 0);
        if (prev_hold) begin
            check(out_valid && out_smooth == prev_sm, "R10 smooth held", out_smooth, prev_sm);
            check(out_deriv == prev_de, "R10 deriv held", out_deriv, prev_de);
        end
        if (st_wr_en) begin
            if (qw_addr.size() == 0) check(0, "R3 unexpected write", st_wr_addr, -1);
            else begin
                int ea;
                logic [3*DW-1:0] ed;
                ea = qw_addr.pop_front(); ed = qw_data.pop_front();
                check(st_wr_addr == ea, "R3 write address", st_wr_addr, ea);
                check(st_wr_data == ed, "R3 R5 R6 write data", st_wr_data, ed);
            end
        end
        if (out_valid && out_ready) begin
            if (q_sm.size() == 0) check(0, "R11 unexpected output", out_smooth, -1);
            else begin
                int es, ed2, ec;
                bit ef;
                string tg;
                es = q_sm.pop_front(); ed2 = q_de.pop_front(); tg = q_tag.pop_front();
                ec = q_cyc.pop_front(); ef = q_fast.pop_front();
                check(int'(out_smooth) == es, tg, out_smooth, es);
                check(int'(out_deriv) == ed2, "R8 R9 deriv", out_deriv, ed2);
                if (ef && cur_fast) check(cyc - ec == 2, "R11 latency", cyc - ec, 2);
            end
        end
        if (acc) begin
            model_accept(pend_pix, pend_addr, pend_sof);
            pend = 0;
        end
        prev_hold = out_valid && !out_ready;
        prev_sm = out_smooth;
        prev_de = out_deriv;
    endtask

    function automatic int gen(input int mode, input int k);
        case (mode)
            0: return 100;
            1: return int'($urandom % 4096);
            2: return 4095;
            3: return 0;
            default: return k * 200;
        endcase
    endfunction

    task automatic run_frame(input int mode, input int rmode);
        int k = 0;
        cur_fast = (rmode == 0);
        while (k < NPIX || pend) begin
            @(negedge clk);
            cyc++;
            case (rmode)
                0: out_ready = 1'b1;
                1: out_ready = ($urandom % 10) < 7;
                default: out_ready = (cyc % 8) >= 5;
            endcase
            if (!pend && k < NPIX && (rmode == 0 || ($urandom % 4) != 0)) begin
                pend = 1; pend_addr = k; pend_sof = (k == 0); pend_pix = gen(mode, k);
                k++;
            end
            in_valid = pend;
            in_addr  = AW'(pend_addr);
            in_sof   = pend_sof;
            in_pix   = PW'(pend_pix);
            #1;
            observe();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(!out_valid, "R1 out_valid", out_valid, 0);
        check(in_ready, "R1 in_ready", in_ready, 1);
        check(!st_wr_en && !st_rd_en, "R1 memory strobes", {st_wr_en, st_rd_en}, 0);
        run_frame(0, 0);   // first frame, zero history (R4), latency (R11)
        run_frame(0, 0);   // second frame-start clears flag (R12)
        run_frame(4, 0);   // ramp
        run_frame(2, 2);   // bright frame under long stalls (R10)
        run_frame(3, 1);   // falling step, negative derivative (R9)
        for (int f = 0; f < 8; f++) run_frame(1, 1 + (f % 2));
        cur_fast = 0;
        for (int i = 0; i < 40 && (q_sm.size() != 0 || qw_addr.size() != 0); i++) begin
            @(negedge clk);
            cyc++;
            in_valid = 1'b0; out_ready = 1'b1;
            #1;
            observe();
        end
        check(q_sm.size() == 0, "R11 all results delivered", q_sm.size(), 0);
        check(qw_addr.size() == 0, "R3 all writes seen", qw_addr.size(), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule